// File: doc/BRIEF.md
# Power-On Reset Sequencer for a Slow-Clock System

This block turns two supply-good indications, one from the always-on backup domain and one from the core domain, into an ordered set of active-low reset outputs: a backup-domain reset, a processor reset, a peripheral reset and an external reset line. It also produces a processor clock enable. Everything runs on the slow oscillator clock. A startup filter lets the oscillator settle before anything leaves reset. The clock enable opens first. After a fixed hold time the resets deassert together, and the external line follows after a programmable stretch.

The block also captures a boot-mode pin a fixed number of clock edges after the core domain comes up, and keeps that value through a later core outage. Two fields are visible to software. The first is a stretch-length field in the backup domain that only a backup-supply loss clears. The second is a reset-cause field that is updated only when the processor reset deasserts.

Top module: `por_seq_ctrl`

## Requirements
- R1: While `bu_por_ok` is low, every reset output, `proc_clk_en`, `cfg_len` and `rst_type` are 0 at once, without waiting for a clock edge, whatever `core_por_ok` shows.
- R2: When both supplies are good, `proc_clk_en` rises on the (2 + STARTUP_CYC)th rising clock edge, counting the first edge after that moment as edge 1. The count is two synchronizer edges plus the startup filter. All reset outputs are still low when it rises.
- R3: `bkup_rst_n`, `proc_rst_n` and `perph_rst_n` rise on the same edge, HOLD_CYC edges after `proc_clk_en` rises.
- R4: `ext_rst_n` rises 2^(L+1) edges after `proc_rst_n` rises, where L is `cfg_len`. That is 2 edges when L = 0. `ext_rst_n` is never high while `proc_rst_n` is low.
- R5: `boot_mode` takes the value that `boot_pin` holds on the 3rd rising edge after both supplies are good. It keeps that value until the next such capture, including while the core supply is down.
- R6: `rst_type` changes only on the edge where `proc_rst_n` rises. It then becomes 3'b000 after a backup-supply power-up and 3'b001 after a return of the core supply alone.
- R7: When `core_por_ok` falls while `bu_por_ok` stays high, `proc_rst_n`, `perph_rst_n` and `ext_rst_n` go low at once. `bkup_rst_n` and `proc_clk_en` stay high.
- R8: After a core-only outage, `proc_rst_n` and `perph_rst_n` rise on edge 2 + HOLD_CYC after `core_por_ok` returns. The startup filter does not run again.
- R9: A write (`cfg_we` high on an edge) loads `cfg_wdata` into `cfg_len` only while `proc_rst_n` is high. Writes during processor reset are ignored. `cfg_len` survives a core-only outage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| bu_por_ok | input | 1 | Backup-supply good, asynchronous, active high |
| core_por_ok | input | 1 | Core-supply good, asynchronous, active high |
| boot_pin | input | 1 | Boot-mode select pin |
| cfg_we | input | 1 | Write strobe for the stretch-length field |
| cfg_wdata | input | LEN_W | Write data for the stretch-length field |
| proc_clk_en | output | 1 | Processor clock enable |
| bkup_rst_n | output | 1 | Backup-domain reset, active low |
| proc_rst_n | output | 1 | Processor reset, active low |
| perph_rst_n | output | 1 | Peripheral reset, active low |
| ext_rst_n | output | 1 | External reset line, active low |
| boot_mode | output | 1 | Captured boot-mode value |
| cfg_len | output | LEN_W | Stretch-length field readback |
| rst_type | output | 3 | Cause of the last reset |

## Verification
The bench measures every release edge from the moment the supplies come good, so an off-by-one in the synchronizer, the startup filter or the hold counter shows up as a shifted edge count. It moves the boot pin just before and just after the capture edge: a design that captures one edge early or late latches the wrong value. Core-only outages are mixed with backup losses. A design that clears the stretch field on a core outage, accepts writes while the processor is in reset, or rewrites the reset cause before release ends up with the wrong `cfg_len`, the wrong external pulse length or the wrong cause. A backup loss with the core still good checks that every output drops without waiting for a clock.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

   typedef enum logic [2:0] {
      RST_GENERAL = 3'b000,
      RST_CORE    = 3'b001
   } rst_kind_e;

   function automatic int unsigned ext_cnt_width(input int unsigned len_w);
      return (1 << len_w) + 2;
   endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("por_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic s0;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) s0 <= 1'b0;
         else         s0 <= d;
      end
      assign q = s0;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) sr <= '0;
         else         sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/por_bkup_dom.sv
module por_bkup_dom
   import por_seq_pkg::*;
#(
   parameter int unsigned STARTUP_CYC = 24,
   parameter int unsigned LEN_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             bu_arst_n,
   input  logic             rel_nxt,
   input  logic             rel_q,
   input  logic             cfg_we,
   input  logic [LEN_W-1:0] cfg_wdata,
   input  logic             boot_stb,
   input  logic             boot_pin,
   output logic             clk_en,
   output logic             bkup_rel,
   output logic [LEN_W-1:0] cfg_len,
   output logic [2:0]       rst_type,
   output logic             boot_q
);

   localparam int unsigned SU_W = $clog2(STARTUP_CYC + 1);

   if (STARTUP_CYC < 1) begin : g_bad_startup
      $error("por_bkup_dom: STARTUP_CYC must be at least 1");
   end

   logic            bu_s;
   logic [SU_W-1:0] su_cnt;
   rst_kind_e       kind_q;

   por_sync #(.STAGES(SYNC_STAGES)) u_bu_sync (
      .clk    (clk),
      .arst_n (bu_arst_n),
      .d      (1'b1),
      .q      (bu_s)
   );

   // startup filter: oscillator settle time before anything is released
   always_ff @(posedge clk or negedge bu_arst_n) begin
      if (!bu_arst_n) begin
         su_cnt <= '0;
         clk_en <= 1'b0;
      end else if (bu_s && !clk_en) begin
         su_cnt <= su_cnt + 1'b1;
         if (su_cnt == SU_W'(STARTUP_CYC - 1)) clk_en <= 1'b1;
      end
   end

   // backup reset releases on the same edge as the first processor release
   always_ff @(posedge clk or negedge bu_arst_n) begin
      if (!bu_arst_n) bkup_rel <= 1'b0;
      else            bkup_rel <= bkup_rel | rel_nxt;
   end

   // stretch-length field, cleared only by backup-supply loss
   always_ff @(posedge clk or negedge bu_arst_n) begin
      if (!bu_arst_n)           cfg_len <= '0;
      else if (cfg_we && rel_q) cfg_len <= cfg_wdata;
   end

   // reset cause, written on the processor release edge only
   always_ff @(posedge clk or negedge bu_arst_n) begin
      if (!bu_arst_n)            kind_q <= RST_GENERAL;
      else if (rel_nxt && !rel_q) kind_q <= bkup_rel ? RST_CORE : RST_GENERAL;
   end
   assign rst_type = kind_q;

   // boot-mode capture survives core outages
   always_ff @(posedge clk or negedge bu_arst_n) begin
      if (!bu_arst_n)    boot_q <= 1'b0;
      else if (boot_stb) boot_q <= boot_pin;
   end

   AST_TYPE_AT_RELEASE: assert property (@(posedge clk) disable iff (!bu_arst_n)
      !$stable(rst_type) |-> $rose(rel_q)); // R6
   AST_LEN_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!bu_arst_n)
      $past(!rel_q) |-> $stable(cfg_len)); // R9

endmodule

// File: rtl/por_core_dom.sv
module por_core_dom
   import por_seq_pkg::*;
#(
   parameter int unsigned HOLD_CYC    = 8,
   parameter int unsigned LEN_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BOOT_DLY    = 3
) (
   input  logic             clk,
   input  logic             core_arst_n,
   input  logic             clk_en,
   input  logic [LEN_W-1:0] cfg_len,
   output logic             rel_nxt,
   output logic             rel_q,
   output logic             perph_q,
   output logic             ext_q,
   output logic             boot_stb
);

   localparam int unsigned HOLD_W = $clog2(HOLD_CYC + 1);
   localparam int unsigned EXT_W  = ext_cnt_width(LEN_W);
   localparam int unsigned BOOT_W = $clog2(BOOT_DLY + 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("por_core_dom: HOLD_CYC must be at least 1");
   end
   if (BOOT_DLY < 1) begin : g_bad_boot
      $error("por_core_dom: BOOT_DLY must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > 5) begin : g_bad_len
      $error("por_core_dom: LEN_W must be 1 to 5");
   end

   logic              core_s;
   logic              hold_go;
   logic [HOLD_W-1:0] hold_cnt;
   logic [EXT_W-1:0]  ext_cnt;
   logic [EXT_W-1:0]  ext_lim;
   logic [LEN_W:0]    ext_sh;
   logic [BOOT_W-1:0] boot_cnt;

   por_sync #(.STAGES(SYNC_STAGES)) u_core_sync (
      .clk    (clk),
      .arst_n (core_arst_n),
      .d      (1'b1),
      .q      (core_s)
   );

   // hold window: clock runs, resets stay asserted
   assign hold_go = clk_en && core_s && !rel_q;
   assign rel_nxt = rel_q | (hold_go && (hold_cnt == HOLD_W'(HOLD_CYC - 1)));

   always_ff @(posedge clk or negedge core_arst_n) begin
      if (!core_arst_n) begin
         hold_cnt <= '0;
         rel_q    <= 1'b0;
         perph_q  <= 1'b0;
      end else begin
         if (hold_go) hold_cnt <= hold_cnt + 1'b1;
         rel_q   <= rel_nxt;
         perph_q <= rel_nxt;
      end
   end

   // external line stretch: 2^(L+1) edges after processor release
   assign ext_sh  = {1'b0, cfg_len} + (LEN_W + 1)'(1);
   assign ext_lim = EXT_W'(1) << ext_sh;

   always_ff @(posedge clk or negedge core_arst_n) begin
      if (!core_arst_n) begin
         ext_cnt <= '0;
         ext_q   <= 1'b0;
      end else if (rel_q && !ext_q) begin
         ext_cnt <= ext_cnt + 1'b1;
         if (ext_cnt == ext_lim - 1'b1) ext_q <= 1'b1;
      end
   end

   // boot-pin capture point, counted from core-domain release
   always_ff @(posedge clk or negedge core_arst_n) begin
      if (!core_arst_n)                       boot_cnt <= '0;
      else if (boot_cnt != BOOT_W'(BOOT_DLY)) boot_cnt <= boot_cnt + 1'b1;
   end
   assign boot_stb = (boot_cnt == BOOT_W'(BOOT_DLY - 1));

   AST_EXT_AFTER_PROC: assert property (@(posedge clk) disable iff (!core_arst_n)
      ext_q |-> rel_q); // R4
   AST_REL_NEEDS_CLKEN: assert property (@(posedge clk) disable iff (!core_arst_n)
      $rose(rel_q) |-> clk_en); // R2

endmodule

// File: rtl/por_seq_ctrl.sv
module por_seq_ctrl
   import por_seq_pkg::*;
#(
   parameter int unsigned STARTUP_CYC = 24,
   parameter int unsigned HOLD_CYC    = 8,
   parameter int unsigned LEN_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BOOT_DLY    = 3
) (
   input  logic             clk,
   input  logic             bu_por_ok,
   input  logic             core_por_ok,
   input  logic             boot_pin,
   input  logic             cfg_we,
   input  logic [LEN_W-1:0] cfg_wdata,
   output logic             proc_clk_en,
   output logic             bkup_rst_n,
   output logic             proc_rst_n,
   output logic             perph_rst_n,
   output logic             ext_rst_n,
   output logic             boot_mode,
   output logic [LEN_W-1:0] cfg_len,
   output logic [2:0]       rst_type
);

   logic core_arst_n;
   logic rel_nxt;
   logic rel_q;
   logic perph_q;
   logic ext_q;
   logic boot_stb;
   logic clk_en;
   logic bkup_rel;

   // a backup loss also drops the core domain
   assign core_arst_n = bu_por_ok & core_por_ok;

   por_bkup_dom #(
      .STARTUP_CYC (STARTUP_CYC),
      .LEN_W       (LEN_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_bkup (
      .clk       (clk),
      .bu_arst_n (bu_por_ok),
      .rel_nxt   (rel_nxt),
      .rel_q     (rel_q),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .boot_stb  (boot_stb),
      .boot_pin  (boot_pin),
      .clk_en    (clk_en),
      .bkup_rel  (bkup_rel),
      .cfg_len   (cfg_len),
      .rst_type  (rst_type),
      .boot_q    (boot_mode)
   );

   por_core_dom #(
      .HOLD_CYC    (HOLD_CYC),
      .LEN_W       (LEN_W),
      .SYNC_STAGES (SYNC_STAGES),
      .BOOT_DLY    (BOOT_DLY)
   ) u_core (
      .clk         (clk),
      .core_arst_n (core_arst_n),
      .clk_en      (clk_en),
      .cfg_len     (cfg_len),
      .rel_nxt     (rel_nxt),
      .rel_q       (rel_q),
      .perph_q     (perph_q),
      .ext_q       (ext_q),
      .boot_stb    (boot_stb)
   );

   assign proc_clk_en = clk_en;
   assign bkup_rst_n  = bkup_rel;
   assign proc_rst_n  = rel_q;
   assign perph_rst_n = perph_q;
   assign ext_rst_n   = ext_q;

   AST_CLKEN_FIRST: assert property (@(posedge clk) disable iff (!bu_por_ok)
      !proc_clk_en |-> (!bkup_rst_n && !proc_rst_n)); // R2
   AST_REL_TOGETHER: assert property (@(posedge clk) disable iff (!bu_por_ok)
      $rose(bkup_rst_n) |-> (proc_rst_n && perph_rst_n)); // R3
   AST_BKUP_KEPT: assert property (@(posedge clk) disable iff (!bu_por_ok)
      bkup_rst_n |=> bkup_rst_n); // R7

endmodule

// File: tb/sim_por_seq_ctrl.sv
module sim_por_seq_ctrl;

   localparam int S  = 24;
   localparam int Y  = 8;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          bu_por_ok = 1'b0;
   logic          core_por_ok = 1'b0;
   logic          boot_pin = 1'b0;
   logic          cfg_we = 1'b0;
   logic [LW-1:0] cfg_wdata = '0;
   logic          proc_clk_en, bkup_rst_n, proc_rst_n, perph_rst_n, ext_rst_n, boot_mode;
   logic [LW-1:0] cfg_len;
   logic [2:0]    rst_type;

   int n_chk  = 0;
   int n_fail = 0;
   int cur_len  = 0;
   int cur_type = 0;
   int last_bv  = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   por_seq_ctrl #(.STARTUP_CYC(S), .HOLD_CYC(Y), .LEN_W(LW)) u0 (
      .clk(clk), .bu_por_ok(bu_por_ok), .core_por_ok(core_por_ok), .boot_pin(boot_pin),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .proc_clk_en(proc_clk_en),
      .bkup_rst_n(bkup_rst_n), .proc_rst_n(proc_rst_n), .perph_rst_n(perph_rst_n),
      .ext_rst_n(ext_rst_n), .boot_mode(boot_mode), .cfg_len(cfg_len), .rst_type(rst_type)
   );

   function automatic int ext_stretch(input int len);
      return 2 << len;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // supplies were raised at the previous negedge; count edges from there
   task automatic seq_run(input bit general, input bit bv, input int exp_type);
      int t_clk = 0, t_bk = 0, t_pr = 0, t_pe = 0, t_ex = 0;
      int typ_before = cur_type;
      int pr_at_clk = 1;
      int lim = 2 + S + Y + ext_stretch(cur_len) + 10;
      for (int cyc = 1; cyc <= lim; cyc++) begin
         @(posedge clk);
         @(negedge clk);
         if (t_clk == 0 && proc_clk_en) begin t_clk = cyc; pr_at_clk = int'(proc_rst_n | bkup_rst_n); end
         if (t_bk == 0 && bkup_rst_n) t_bk = cyc;
         if (t_pr == 0 && proc_rst_n) t_pr = cyc;
         if (t_pe == 0 && perph_rst_n) t_pe = cyc;
         if (t_ex == 0 && ext_rst_n) t_ex = cyc;
         if (!proc_rst_n) typ_before = int'(rst_type);
         if (cyc == 2) boot_pin = bv;
         if (cyc == 3) boot_pin = ~bv;
         if (t_ex != 0) break;
      end
      if (general) begin
         check("R2 clock enable edge", t_clk, 2 + S);
         check("R2 resets low at clock enable", pr_at_clk, 0);
         check("R3 backup release edge", t_bk, 2 + S + Y);
         check("R3 processor with backup", t_pr, t_bk);
      end else begin
         check("R7 backup kept released", t_bk, 1);
         check("R7 clock enable kept", t_clk, 1);
         check("R8 processor release edge", t_pr, 2 + Y);
      end
      check("R3 peripheral with processor", t_pe, t_pr);
      check("R4 external stretch", t_ex - t_pr, ext_stretch(cur_len));
      check("R6 cause held before release", typ_before, cur_type);
      check("R6 cause after release", int'(rst_type), exp_type);
      check("R5 boot capture", int'(boot_mode), int'(bv));
      cur_type = exp_type;
      last_bv  = int'(bv);
   endtask

   task automatic backup_cycle(input bit bv);
      @(negedge clk);
      bu_por_ok = 1'b0;
      #1;
      check("R1 all resets low", int'({bkup_rst_n, proc_rst_n, perph_rst_n, ext_rst_n}), 0);
      check("R1 clock enable low", int'(proc_clk_en), 0);
      check("R1 fields cleared", int'({cfg_len, rst_type}), 0);
      cur_len = 0;
      cur_type = 0;
      repeat (3) @(negedge clk);
      boot_pin = ~bv;
      @(negedge clk);
      bu_por_ok = 1'b1;
      core_por_ok = 1'b1;
      seq_run(1'b1, bv, 0);
   endtask

   task automatic core_cycle(input bit bv);
      @(negedge clk);
      core_por_ok = 1'b0;
      #1;
      check("R7 processor and peripheral low", int'({proc_rst_n, perph_rst_n}), 0);
      check("R4 external low with processor", int'(ext_rst_n), 0);
      check("R7 backup and clock enable kept", int'({bkup_rst_n, proc_clk_en}), 3);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = LW'(cur_len ^ 5);
      @(negedge clk);
      cfg_we = 1'b0;
      check("R9 write ignored in reset", int'(cfg_len), cur_len);
      check("R5 boot held while core down", int'(boot_mode), last_bv);
      boot_pin = ~bv;
      @(negedge clk);
      core_por_ok = 1'b1;
      seq_run(1'b0, bv, 1);
   endtask

   task automatic write_len(input int v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = LW'(v);
      @(negedge clk);
      cfg_we = 1'b0;
      check("R9 write accepted", int'(cfg_len), v);
      cur_len = v;
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int r;
      r = $urandom(32'd4411);
      repeat (3) @(negedge clk);
      check("R1 reset state outputs", int'({proc_clk_en, bkup_rst_n, proc_rst_n, perph_rst_n, ext_rst_n}), 0);
      check("R1 reset state fields", int'({cfg_len, rst_type}), 0);

      backup_cycle(1'b1);
      write_len(3);
      core_cycle(1'b0);
      check("R9 length kept after core outage", int'(cfg_len), 3);
      backup_cycle(1'b0);
      write_len(15);
      core_cycle(1'b1);

      for (int it = 0; it < 10; it++) begin
         bit bv;
         bv = 1'($urandom);
         write_len(int'($urandom_range(0, 6)));
         if ($urandom_range(0, 2) == 0) backup_cycle(bv);
         else                           core_cycle(bv);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule